// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the six base registers, the expansion ROM register and the two space-enable bits of a configuration header into a set of decoded address windows. Each window has a fixed power-of-two size and a fixed I/O or memory type, both set at build time. For every window the block presents a valid flag and the aligned base address. It also presents a one-cycle change strobe whenever a window's valid flag or base moves, so that the address decode further along the chip can re-program itself.

The register contents are held elsewhere and arrive as plain inputs. The block observes the configuration write stream (offset, length, enable) only to decide when to re-evaluate. Re-evaluation happens on a full-dword write into the base or ROM register range, or on any write that covers a byte of the command word. Windows that fail validation are reported as unmapped: valid low and base zero. A failed window never yields a partial or wrapped range.

Top module: `bar_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, every window reports valid 0, base 0 and change strobe 0.
- R2: A re-evaluation is triggered by `wr_en` with either of two kinds of write. The first is a 4-byte write whose start offset lies in 0x10..0x27 or 0x30..0x33. The second is a write of any length whose byte range overlaps offsets 0x04..0x05. Length code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The outputs take the new values on the same clock edge that samples the write.
- R3: Any other write leaves every output unchanged and raises no strobe. This covers 1-byte and 2-byte writes into the base range and writes that miss the command bytes. Register or enable changes without a trigger also have no effect.
- R4: The enables are as follows. An I/O window needs `io_space_en` (command bit 0), and a memory window needs `mem_space_en` (command bit 1). The ROM window (index 6) is a memory window that also needs bit 0 of its own register set.
- R5: The reported base is the register value ANDed with the inverse of (size - 1). An unmapped window reports base 0.
- R6: A window whose aligned base is zero, or whose last address (base + size - 1) is not above the base, is unmapped.
- R7: An I/O window whose last address is 0x10000 or higher is unmapped. A memory window whose last address is all ones is unmapped.
- R8: A window built with size zero is never valid.
- R9: A window's change strobe is high for exactly the one cycle after a re-evaluation that altered its valid flag or its base. If neither changed, no strobe is raised.
- R10: Windows 0..5 follow base registers 0..5, and window 6 follows the ROM register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_space_en | input | 1 | Command bit 0: I/O space decode enable |
| mem_space_en | input | 1 | Command bit 1: memory space decode enable |
| bar_reg | input | 6x32 | Current contents of base registers 0..5 |
| rom_reg | input | 32 | Current contents of the expansion ROM register |
| wr_en | input | 1 | A configuration write is presented this cycle |
| wr_addr | input | 8 | Byte offset of that write |
| wr_len | input | 2 | Length code of that write (0:1, 1:2, 2/3:4 bytes) |
| win_valid | output | 7 | Window mapped flags, bit 6 is the ROM window |
| win_base | output | 7x32 | Aligned base per window, zero when unmapped |
| win_chg | output | 7 | One-cycle strobe per window on a changed result |

## Verification
The bench targets the validation edges. These include an I/O window ending exactly at 0xFFFF next to one crossing into 0x10000, a memory window ending at all ones, a base that masks down to zero, and a ROM register with its enable bit clear. A decoder with an off-by-one on the I/O limit, or one that skips the ROM bit, would map those windows. Narrow writes into the base range and writes just beside the command word are sent to catch a trigger decode that is too wide. A 2-byte write straddling offsets 0x03..0x04 catches one that is too narrow. Repeated identical re-evaluations check that a strobe that fires on every trigger, instead of on a real difference, is reported.

// File: rtl/bwd_pkg.sv
// Shared definitions for the base address window decoder.
// Assumes byte-addressed configuration offsets of 8 bits.
package bwd_pkg;

    // Encoding of the configuration write length input.
    typedef enum logic [1:0] {
        LEN_1B  = 2'd0,
        LEN_2B  = 2'd1,
        LEN_4B  = 2'd2,
        LEN_4BX = 2'd3
    } wr_len_e;

    // Offsets whose writes cause a re-evaluation.
    localparam logic [8:0] CMD_LO  = 9'h004;
    localparam logic [8:0] CMD_HI  = 9'h005;
    localparam logic [7:0] BAR_LO  = 8'h10;
    localparam logic [7:0] BAR_HI  = 8'h27;
    localparam logic [7:0] ROM_LO  = 8'h30;
    localparam logic [7:0] ROM_HI  = 8'h33;

    // Number of bytes covered by a length code.
    function automatic logic [2:0] len_bytes(wr_len_e l);
        case (l)
            LEN_1B:  return 3'd1;
            LEN_2B:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bwd_write_snoop.sv
// Watches the configuration write stream and flags writes that require the
// windows to be recomputed: a dword write into the base or ROM range, or a
// write of any length that covers a command byte.
// Assumes the written data is already visible on the register inputs in the
// cycle the write is presented.
module bwd_write_snoop
    import bwd_pkg::*;
(
    input  logic       wr_en_i,
    input  logic [7:0] wr_addr_i,
    input  logic [1:0] wr_len_i,
    output logic       load_o
);

    logic [2:0] nbytes;
    logic [8:0] start_b;
    logic [8:0] end_ex;
    logic       cmd_hit;
    logic       bar_hit;

    // Decode the byte range of the write and test both trigger conditions.
    always_comb begin
        nbytes  = len_bytes(wr_len_e'(wr_len_i));
        start_b = {1'b0, wr_addr_i};
        end_ex  = start_b + {6'd0, nbytes};
        cmd_hit = (start_b <= CMD_HI) && (end_ex > CMD_LO);
        bar_hit = (nbytes == 3'd4) &&
                  (((wr_addr_i >= BAR_LO) && (wr_addr_i <= BAR_HI)) ||
                   ((wr_addr_i >= ROM_LO) && (wr_addr_i <= ROM_HI)));
        load_o  = wr_en_i && (cmd_hit || bar_hit);
    end

endmodule

// File: rtl/bwd_window_eval.sv
// Combinational validation of one window: aligns the register value to the
// window size, applies the space enable (and ROM enable bit), and rejects a
// zero base, a wrapped range, an I/O range past IO_LIMIT or a memory range
// ending at all ones.
// Assumes SIZE is zero or a power of two.
module bwd_window_eval #(
    parameter int unsigned     AW       = 32,
    parameter logic [AW-1:0]   SIZE     = '0,
    parameter bit              IS_IO    = 1'b0,
    parameter bit              IS_ROM   = 1'b0,
    parameter logic [AW-1:0]   IO_LIMIT = AW'(32'h0001_0000)
) (
    input  logic [AW-1:0] reg_i,
    input  logic          io_en_i,
    input  logic          mem_en_i,
    output logic          ok_o,
    output logic [AW-1:0] base_o
);

    localparam logic [AW-1:0] SPAN = SIZE - 1'b1;
    localparam logic [AW-1:0] MASK = ~SPAN;
    localparam bit            SIZED = (SIZE != '0);
    localparam bit            IO_KIND = IS_IO && !IS_ROM;

    logic [AW-1:0] masked;
    logic [AW-1:0] last;
    logic          enabled;
    logic          range_bad;
    logic          limit_bad;

    // Align, bound-check and enable-check the window.
    always_comb begin
        masked    = reg_i & MASK;
        last      = masked + SPAN;
        if (IS_ROM)
            enabled = mem_en_i && reg_i[0];
        else if (IS_IO)
            enabled = io_en_i;
        else
            enabled = mem_en_i;
        range_bad = (masked == '0) || (last <= masked);
        if (IO_KIND)
            limit_bad = (last >= IO_LIMIT);
        else
            limit_bad = (last == '1);
        ok_o   = SIZED && enabled && !range_bad && !limit_bad;
        base_o = ok_o ? masked : '0;
    end

endmodule

// File: rtl/bwd_window_reg.sv
// Holds the published state of one window and raises a one-cycle strobe when
// a recompute changes either the valid flag or the base.
// Assumes load_i is a single-cycle qualifier from the write snoop.
module bwd_window_reg #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          ok_i,
    input  logic [AW-1:0] base_i,
    output logic          valid_o,
    output logic [AW-1:0] base_o,
    output logic          chg_o
);

    logic differs;

    // Compare the fresh result against the published one.
    always_comb differs = (ok_i != valid_o) || (base_i != base_o);

    // Publish a new result on load and pulse the strobe if it moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            base_o  <= '0;
            chg_o   <= 1'b0;
        end else begin
            chg_o <= load_i && differs;
            if (load_i) begin
                valid_o <= ok_i;
                base_o  <= base_i;
            end
        end
    end

    // R9
    chg_needs_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> ((valid_o != $past(valid_o)) || (base_o != $past(base_o))));

    // R2
    chg_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> $past(load_i));

    // R3
    hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> ($stable(valid_o) && $stable(base_o)));

    // R5
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (base_o == '0));

    // R6
    valid_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (base_o != '0));

endmodule

// File: rtl/bar_window_decoder.sv
// Top of the base address window decoder: one evaluator and one state
// register per base register plus one for the expansion ROM register,
// all recomputed together when the write snoop flags a relevant write.
// Assumes register storage lives outside and is current when written.
module bar_window_decoder #(
    parameter int unsigned   NUM_BAR  = 6,
    parameter int unsigned   AW       = 32,
    parameter logic [AW-1:0] IO_LIMIT = AW'(32'h0001_0000),
    parameter logic [AW-1:0] WIN_SIZE [NUM_BAR+1] = '{
        AW'(32'h0000_0100), AW'(32'h0000_1000), AW'(32'h0010_0000),
        AW'(32'h0000_0000), AW'(32'h0000_0010), AW'(32'h0000_1000),
        AW'(32'h0001_0000)},
    parameter logic [NUM_BAR:0] WIN_IO = 7'b001_0001
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          io_space_en,
    input  logic                          mem_space_en,
    input  logic [NUM_BAR-1:0][AW-1:0]    bar_reg,
    input  logic [AW-1:0]                 rom_reg,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_addr,
    input  logic [1:0]                    wr_len,
    output logic [NUM_BAR:0]              win_valid,
    output logic [NUM_BAR:0][AW-1:0]      win_base,
    output logic [NUM_BAR:0]              win_chg
);

    localparam int unsigned NUM_WIN = NUM_BAR + 1;
    localparam int unsigned ROM_IDX = NUM_BAR;

    logic load;

    bwd_write_snoop u_snoop (
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_len_i  (wr_len),
        .load_o    (load)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam bit            W_ROM  = (i == ROM_IDX);
        localparam bit            W_IO   = W_ROM ? 1'b0 : WIN_IO[i];
        localparam logic [AW-1:0] W_SPAN = WIN_SIZE[i] - 1'b1;

        logic [AW-1:0] src;
        logic          ok;
        logic [AW-1:0] base;

        if (W_ROM) begin : g_src_rom
            // Window fed by the expansion ROM register.
            always_comb src = rom_reg;
        end else begin : g_src_bar
            // Window fed by its base register.
            always_comb src = bar_reg[i];
        end

        bwd_window_eval #(
            .AW       (AW),
            .SIZE     (WIN_SIZE[i]),
            .IS_IO    (W_IO),
            .IS_ROM   (W_ROM),
            .IO_LIMIT (IO_LIMIT)
        ) u_eval (
            .reg_i    (src),
            .io_en_i  (io_space_en),
            .mem_en_i (mem_space_en),
            .ok_o     (ok),
            .base_o   (base)
        );

        bwd_window_reg #(
            .AW (AW)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .ok_i    (ok),
            .base_i  (base),
            .valid_o (win_valid[i]),
            .base_o  (win_base[i]),
            .chg_o   (win_chg[i])
        );

        if (W_IO) begin : g_io_chk
            // R7
            io_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                win_valid[i] |-> ((win_base[i] + W_SPAN) < IO_LIMIT));
        end else begin : g_mem_chk
            // R7
            mem_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
                win_valid[i] |-> ((win_base[i] + W_SPAN) != '1));
        end
    end

endmodule

// File: tb/bar_window_decoder_tb.sv
module bar_window_decoder_tb;

    localparam int NV = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             io_en, mem_en;
    logic [5:0][31:0] bar_reg;
    logic [31:0]      rom_reg;
    logic             wr_en;
    logic [7:0]       wr_addr;
    logic [1:0]       wr_len;
    logic [6:0]       win_valid;
    logic [6:0][31:0] win_base;
    logic [6:0]       win_chg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bar_window_decoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_space_en  (io_en),
        .mem_space_en (mem_en),
        .bar_reg      (bar_reg),
        .rom_reg      (rom_reg),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_len       (wr_len),
        .win_valid    (win_valid),
        .win_base     (win_base),
        .win_chg      (win_chg)
    );

    // Stimulus: command bits, register contents (bar0..bar5, rom).
    localparam logic [1:0] T_CMD [NV] = '{2'd3, 2'd1, 2'd2, 2'd3, 2'd3, 2'd3};
    localparam logic [31:0] T_REG [NV][7] = '{
        '{32'h0000_C001, 32'hE000_1234, 32'hF00A_5678, 32'h1234_0000, 32'h0000_D0F1, 32'h8000_0000, 32'hC001_0001},
        '{32'h0000_C001, 32'hE000_1234, 32'hF00A_5678, 32'h1234_0000, 32'h0000_D0F1, 32'h8000_0000, 32'hC001_0001},
        '{32'h0000_C001, 32'hE000_1234, 32'hF00A_5678, 32'h1234_0000, 32'h0000_D0F1, 32'h8000_0000, 32'hC001_0001},
        '{32'h0000_FF01, 32'h0000_0FFF, 32'hFFF0_0000, 32'h1234_0000, 32'h0001_0001, 32'hFFFF_E000, 32'hC001_0000},
        '{32'h0000_FF01, 32'h0000_0FFF, 32'hFFF0_0000, 32'h1234_0000, 32'h0001_0001, 32'hFFFF_E000, 32'hC001_0000},
        '{32'h0000_FFF1, 32'h0000_1000, 32'hFFF0_0000, 32'h1234_0000, 32'h0000_FFF1, 32'hFFFF_E000, 32'h0000_0001}};
    // Expected valid flags, change strobes and bases.
    localparam logic [6:0] T_EV [NV] = '{7'h77, 7'h11, 7'h66, 7'h21, 7'h21, 7'h33};
    localparam logic [6:0] T_EC [NV] = '{7'h77, 7'h66, 7'h77, 7'h67, 7'h00, 7'h12};
    localparam logic [31:0] T_EB [NV][7] = '{
        '{32'h0000_C000, 32'hE000_1000, 32'hF000_0000, 32'h0, 32'h0000_D0F0, 32'h8000_0000, 32'hC001_0000},
        '{32'h0000_C000, 32'h0, 32'h0, 32'h0, 32'h0000_D0F0, 32'h0, 32'h0},
        '{32'h0, 32'hE000_1000, 32'hF000_0000, 32'h0, 32'h0, 32'h8000_0000, 32'hC001_0000},
        '{32'h0000_FF00, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_E000, 32'h0},
        '{32'h0000_FF00, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_E000, 32'h0},
        '{32'h0000_FF00, 32'h0000_1000, 32'h0, 32'h0, 32'h0000_FFF0, 32'hFFFF_E000, 32'h0}};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one write at a falling edge, then wait until after the next rising edge.
    task automatic do_write(input logic en, input logic [7:0] a, input logic [1:0] l);
        wr_en   = en;
        wr_addr = a;
        wr_len  = l;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; io_en = 1'b0; mem_en = 1'b0;
        bar_reg = '0; rom_reg = '0;
        wr_en = 1'b0; wr_addr = '0; wr_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 valid", {25'd0, win_valid}, 32'h0);
        chk("R1 chg", {25'd0, win_chg}, 32'h0);
        for (int w = 0; w < 7; w++) chk("R1 base", win_base[w], 32'h0);

        // Table walk: each vector triggered by a dword write at 0x10 (R2, R4..R10)
        for (int v = 0; v < NV; v++) begin
            io_en  = T_CMD[v][0];
            mem_en = T_CMD[v][1];
            for (int k = 0; k < 6; k++) bar_reg[k] = T_REG[v][k];
            rom_reg = T_REG[v][6];
            do_write(1'b1, 8'h10, 2'd2);
            chk($sformatf("R4 R6 R7 R8 valid v%0d", v), {25'd0, win_valid}, {25'd0, T_EV[v]});
            chk($sformatf("R9 chg v%0d", v), {25'd0, win_chg}, {25'd0, T_EC[v]});
            for (int w = 0; w < 7; w++)
                chk($sformatf("R5 R10 base v%0d w%0d", v, w), win_base[w], T_EB[v][w]);
            @(negedge clk);
            chk($sformatf("R9 chg one cycle v%0d", v), {25'd0, win_chg}, 32'h0);
        end

        // R3: narrow writes into the base range do not re-evaluate
        bar_reg[1] = 32'h2000_0000;
        do_write(1'b1, 8'h14, 2'd0);
        chk("R3 1B bar write base", win_base[1], 32'h0000_1000);
        chk("R3 1B bar write chg", {25'd0, win_chg}, 32'h0);
        do_write(1'b1, 8'h14, 2'd1);
        chk("R3 2B bar write base", win_base[1], 32'h0000_1000);
        // R3: wr_en low does nothing
        do_write(1'b0, 8'h14, 2'd2);
        chk("R3 no enable base", win_base[1], 32'h0000_1000);
        // R2: length code 3 counts as a dword
        do_write(1'b1, 8'h14, 2'd3);
        chk("R2 len3 base", win_base[1], 32'h2000_0000);
        chk("R2 len3 chg", {25'd0, win_chg}, 32'h02);

        // R3: write beside the command word is ignored
        mem_en = 1'b0;
        do_write(1'b1, 8'h06, 2'd0);
        chk("R3 offset 6 valid", {25'd0, win_valid}, 32'h33);
        // R2 R4: 1-byte write on command upper byte re-evaluates
        do_write(1'b1, 8'h05, 2'd0);
        chk("R2 R4 cmd byte valid", {25'd0, win_valid}, 32'h11);
        chk("R2 R4 cmd byte chg", {25'd0, win_chg}, 32'h22);
        // R2: 2-byte write at 0x03 reaches 0x04
        mem_en = 1'b1;
        do_write(1'b1, 8'h03, 2'd1);
        chk("R2 straddle valid", {25'd0, win_valid}, 32'h33);
        chk("R2 straddle chg", {25'd0, win_chg}, 32'h22);
        // R4: ROM enable bit set, dword write at ROM offset
        rom_reg = 32'hC001_0001;
        do_write(1'b1, 8'h30, 2'd2);
        chk("R4 rom valid", {25'd0, win_valid}, 32'h73);
        chk("R4 rom base", win_base[6], 32'hC001_0000);
        chk("R4 rom chg", {25'd0, win_chg}, 32'h40);
        // R9: same values again, no strobe
        do_write(1'b1, 8'h30, 2'd2);
        chk("R9 repeat chg", {25'd0, win_chg}, 32'h0);

        finish_run();
    end

endmodule